// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave side of a three-wire serial port. An external host uses it to read and write a small byte-wide configuration register file. The host provides a serial clock, an active-low chip select and one shared data line. This block presents that line as a split input, output and output-enable, so the pad can be wired outside it.

Every frame opens with a 16-bit instruction sent most significant bit first:

| Bit(s) | Meaning |
|---|---|
| 15 | Direction: 1 = read, 0 = write |
| 14:13 | Length code |
| 12:0 | Start address |

One or more 8-bit data words follow the instruction. On a read, the block takes over the data line for the data phase. The address steps after each byte. The host may keep chip select low to stream further bytes. It may also raise chip select between bytes to pause a counted transfer.

All serial inputs are synchronised into the system clock `clk`, and every edge of the serial clock is detected there. The serial clock must therefore run well below `clk`. The register contents are also available in parallel on `cfg_regs`, so neighbouring logic can use the settings.

Top module: `spi3_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, the data output enable is low, and data words use MSB-first order.
- R2: A write frame (bit 15 = 0) stores each received data byte at the current address on the system clock cycle that follows detection of that byte's eighth serial clock rising edge. The stored byte then appears on `cfg_regs` at bits [8*addr+7 : 8*addr].
- R3: On a read frame (bit 15 = 1), the output enable rises after the sixteenth instruction bit. The block then drives the addressed register one bit per serial clock cycle. Each bit changes after a falling serial clock edge and is valid at the following rising edge. No register is written while the output enable is high.
- R4: Length code 00, 01 and 10 count 1, 2 and 3 data bytes. Code 11 counts none, so the frame streams until chip select rises. If chip select stays low after the counted bytes, more bytes keep transferring.
- R5: After each data byte the address moves by one. It decrements in MSB-first order and increments in LSB-first order, and it wraps within 13 bits.
- R6: Bit 0 of register 0 selects LSB-first order (1) or MSB-first order (0) for data bytes. The value is taken when the instruction completes and holds for the whole frame. The instruction itself is always sent MSB-first.
- R7: If chip select goes high on a byte boundary before the counted bytes are done, the frame pauses. When chip select returns low, the transfer resumes at the next byte and address.
- R8: While chip select is high, the output enable is low.
- R9: Writes to addresses at or above the register count are ignored, and leave `cfg_regs` unchanged. Reads from those addresses return 0x00.
- R10: If chip select rises in the middle of an instruction or a data byte, the frame is aborted. The partial byte is never written.
- R11: If chip select rises on a byte boundary once the counted bytes are done, the frame ends. This includes code 11 with no data at all. The next chip select low then starts a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Data driven toward the pad on reads |
| sdio_oe | output | 1 | Output enable for the data line pad |
| cfg_regs | output | NREGS*8 | Parallel view of all registers; register k sits at bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults: 16 registers, a two-stage synchroniser, and the order bit at register 0 bit 0. With only 16 registers, random addresses of 0 to 19 and the wrap below address 0 put many transfers into the unmapped region. These cover ignored writes and zero reads, and also cover streams that cross from mapped into unmapped addresses.

The serial clock half period is six system clocks. That leaves room for the synchroniser latency, so readback bits are checked at the instant the host would sample them.

Random frames mix both bit orders, since writes to register 0 flip the order. They also cover all four length codes, streaming beyond the count, and pauses on byte boundaries.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

    localparam int ADDR_W  = 13;
    localparam int INSTR_W = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_DATA  = 2'd2
    } frame_st_t;

    typedef struct packed {
        logic              rd;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    // number of counted bytes; the streaming code counts none
    function automatic logic [1:0] len_count(input logic [1:0] code);
        return (code == 2'b11) ? 2'd0 : code + 2'd1;
    endfunction

    function automatic logic [2:0] bit_slot(input logic lsb, input logic [2:0] idx);
        return lsb ? idx : 3'd7 - idx;
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic lsb,
                                                   input logic [BYTE_W-1:0] cur,
                                                   input logic b);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic lsb,
                                                    input logic [ADDR_W-1:0] a);
        return lsb ? a + ADDR_W'(1) : a - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
    import spi3_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [NREGS*BYTE_W-1:0] regs_flat
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NREGS);

    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr < LIMIT);

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[r*BYTE_W +: BYTE_W] <= '0;
            else if (wr_hit && (wr_addr == ADDR_W'(r)))
                regs_flat[r*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREGS; r++)
            if (rd_addr == ADDR_W'(r))
                rd_data = regs_flat[r*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
    import spi3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csb_s,
    input  logic              sdi_s,
    input  logic              lsb_cfg,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              in_data,
    output logic              sdo,
    output logic              oe
);
    frame_st_t         state;
    logic              sclk_d, csb_d;
    logic              rise, fall, csb_fall;
    logic [INSTR_W-2:0] sreg;
    logic [3:0]        bcnt;
    logic [1:0]        left;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q, lsb_q;
    logic [BYTE_W-1:0] dbyte;
    logic              dout_q;
    instr_t            ins;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csb_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csb_d  <= csb_s;
        end
    end

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign csb_fall = csb_d & ~csb_s;
    assign ins      = instr_t'({sreg, sdi_s});

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sreg   <= '0;
            bcnt   <= '0;
            left   <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            lsb_q  <= 1'b0;
            dbyte  <= '0;
        end else if (csb_s) begin
            unique case (state)
                ST_INSTR: state <= ST_IDLE;
                ST_DATA:  if (bcnt != 4'd0 || left == 2'd0) state <= ST_IDLE;
                default:  ;
            endcase
        end else if (rise) begin
            unique case (state)
                ST_IDLE: begin
                    sreg  <= {{(INSTR_W-2){1'b0}}, sdi_s};
                    bcnt  <= 4'd1;
                    state <= ST_INSTR;
                end
                ST_INSTR: begin
                    if (bcnt == 4'd15) begin
                        rd_q   <= ins.rd;
                        left   <= len_count(ins.len);
                        addr_q <= ins.addr;
                        lsb_q  <= lsb_cfg;
                        bcnt   <= 4'd0;
                        state  <= ST_DATA;
                    end else begin
                        sreg <= {sreg[INSTR_W-3:0], sdi_s};
                        bcnt <= bcnt + 4'd1;
                    end
                end
                ST_DATA: begin
                    dbyte <= shift_in(lsb_q, dbyte, sdi_s);
                    if (bcnt == 4'd7) begin
                        bcnt   <= 4'd0;
                        addr_q <= step_addr(lsb_q, addr_q);
                        if (left != 2'd0) left <= left - 2'd1;
                    end else begin
                        bcnt <= bcnt + 4'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // readback bit launch on falling serial edge, or on resume after a pause
    always_ff @(posedge clk) begin
        if (rst)
            dout_q <= 1'b0;
        else if ((fall || csb_fall) && state == ST_DATA && rd_q)
            dout_q <= rd_byte[bit_slot(lsb_q, bcnt[2:0])];
    end

    assign wr_req   = rise && !csb_s && state == ST_DATA && !rd_q && bcnt == 4'd7;
    assign wr_data  = shift_in(lsb_q, dbyte, sdi_s);
    assign cur_addr = addr_q;
    assign in_data  = (state == ST_DATA);
    assign sdo      = dout_q;
    assign oe       = (state == ST_DATA) && rd_q && !csb_s;
endmodule

// File: rtl/spi3_cfg_port.sv
module spi3_cfg_port
    import spi3_pkg::*;
#(
    parameter int NREGS       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ORDER_REG   = 0,
    parameter int ORDER_BIT   = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    csb,
    input  logic                    sdio_in,
    output logic                    sdio_out,
    output logic                    sdio_oe,
    output logic [NREGS*BYTE_W-1:0] cfg_regs
);
    localparam int ORDER_POS = ORDER_REG * BYTE_W + ORDER_BIT;

    logic [2:0]        sync_q;
    logic              fr_wr_req;
    logic [BYTE_W-1:0] fr_wr_data;
    logic [ADDR_W-1:0] fr_addr;
    logic              fr_in_data;
    logic [BYTE_W-1:0] rf_rd_data;

    spi3_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in ({csb, sclk, sdio_in}),
        .d_out(sync_q)
    );

    spi3_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_q[1]),
        .csb_s   (sync_q[2]),
        .sdi_s   (sync_q[0]),
        .lsb_cfg (cfg_regs[ORDER_POS]),
        .rd_byte (rf_rd_data),
        .wr_req  (fr_wr_req),
        .wr_data (fr_wr_data),
        .cur_addr(fr_addr),
        .in_data (fr_in_data),
        .sdo     (sdio_out),
        .oe      (sdio_oe)
    );

    spi3_regfile #(.NREGS(NREGS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fr_wr_req),
        .wr_addr  (fr_addr),
        .wr_data  (fr_wr_data),
        .rd_addr  (fr_addr),
        .rd_data  (rf_rd_data),
        .regs_flat(cfg_regs)
    );
endmodule

// File: rtl/spi3_cfg_chk.sv
module spi3_cfg_chk #(
    parameter int NREGS  = 16,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              csb,
    input logic              sdio_oe,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NREGS*8-1:0] cfg_regs,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              in_data
);
    // R8
    oe_released_chk: assert property (@(posedge clk) disable iff (rst)
        (csb && $past(csb) && $past(csb, 2)) |-> !sdio_oe);

    // R3
    no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !wr_req);

    // R2
    single_write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);

    // R9
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_addr >= ADDR_W'(NREGS)) |=> (cfg_regs == $past(cfg_regs)));

    // R5
    addr_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_data && $past(in_data) && cur_addr != $past(cur_addr)) |->
        ((cur_addr == $past(cur_addr) + ADDR_W'(1)) ||
         (cur_addr == $past(cur_addr) - ADDR_W'(1))));
endmodule

bind spi3_cfg_port spi3_cfg_chk #(.NREGS(NREGS), .ADDR_W(13)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .csb     (csb),
    .sdio_oe (sdio_oe),
    .wr_req  (fr_wr_req),
    .wr_addr (fr_addr),
    .cfg_regs(cfg_regs),
    .cur_addr(fr_addr),
    .in_data (fr_in_data)
);

// File: tb/sim_spi3_cfg_port.sv
module sim_spi3_cfg_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NREGS      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csb = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic [NREGS*8-1:0] cfg_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit [7:0] model [NREGS];
    bit [7:0] wbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi3_cfg_port #(.NREGS(NREGS)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_regs(cfg_regs)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] model_rd(input bit [12:0] a);
        return (a < NREGS) ? model[a[3:0]] : 8'h00;
    endfunction

    function automatic bit [12:0] next_addr(input bit lsb, input bit [12:0] a);
        return lsb ? a + 13'd1 : a - 13'd1;
    endfunction

    function automatic logic [127:0] model_flat();
        logic [127:0] f = '0;
        for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic bit_cycle(input logic din, output logic dout, output logic oe);
        sdio_in = din;
        repeat (HALF) @(negedge clk);
        dout = sdio_out;
        oe   = sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic cs_low();
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        csb = 1'b1;
        repeat (HALF + 4) @(negedge clk);
    endtask

    task automatic send_instr(input bit rd, input bit [1:0] wc, input bit [12:0] a);
        logic [15:0] w;
        logic d, o;
        w = {rd, wc, a};
        for (int i = 15; i >= 0; i--) bit_cycle(w[i], d, o);
    endtask

    task automatic run_frame(input string tag, input bit rd, input bit [1:0] wc,
                             input bit [12:0] a0, input int nb, input int stall_at);
        bit lsb;
        bit [12:0] a;
        bit [7:0] eb, got;
        logic d, o, oe_all;
        lsb = model[0][0];
        a = a0;
        oe_all = 1'b1;
        cs_low();
        send_instr(rd, wc, a0);
        for (int k = 0; k < nb; k++) begin
            if (k == stall_at) begin
                cs_high();
                check({tag, " R8 oe low during pause"}, sdio_oe, 1'b0);
                cs_low();
            end
            eb = rd ? model_rd(a) : wbuf[k];
            got = '0;
            for (int i = 0; i < 8; i++) begin
                int p;
                p = lsb ? i : 7 - i;
                bit_cycle(rd ? 1'b0 : eb[p], d, o);
                got[p] = d;
                oe_all &= (o === 1'b1);
            end
            if (rd) check({tag, " R3 readback byte"}, got, eb);
            else if (a < NREGS) model[a[3:0]] = eb;
            a = next_addr(lsb, a);
        end
        cs_high();
        if (rd && nb > 0) check({tag, " R3 oe through data"}, oe_all, 1'b1);
        check({tag, " R8 oe released"}, sdio_oe, 1'b0);
        if (!rd) check({tag, " R2 register contents"}, cfg_regs, model_flat());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic d, o;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 registers", cfg_regs, '0);
        check("R1 oe", sdio_oe, 1'b0);

        wbuf[0] = 8'hA5;
        run_frame("R2 single write", 1'b0, 2'b00, 13'd3, 1, -1);
        run_frame("R3 single read", 1'b1, 2'b00, 13'd3, 1, -1);

        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        run_frame("R4 R5 three byte write", 1'b0, 2'b10, 13'd9, 3, -1);
        check("R5 decrement lands at 7", cfg_regs[7*8 +: 8], 8'h33);
        run_frame("R4 three byte read", 1'b1, 2'b10, 13'd9, 3, -1);

        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
        run_frame("R4 stream past count", 1'b0, 2'b00, 13'd12, 3, -1);
        for (int k = 0; k < 5; k++) wbuf[k] = 8'h80 + 8'(k);
        run_frame("R4 stream code", 1'b0, 2'b11, 13'd6, 5, -1);

        wbuf[0] = 8'hEE;
        run_frame("R9 unmapped write", 1'b0, 2'b00, 13'd20, 1, -1);
        run_frame("R9 unmapped read", 1'b1, 2'b01, 13'd0, 2, -1);

        wbuf[0] = 8'h91; wbuf[1] = 8'h92; wbuf[2] = 8'h93;
        run_frame("R7 paused write", 1'b0, 2'b10, 13'd15, 3, 1);
        run_frame("R7 paused read", 1'b1, 2'b10, 13'd15, 3, 2);

        // R10 abort in mid-byte: partial byte of reg 4 must not land
        cs_low();
        send_instr(1'b0, 2'b00, 13'd4);
        for (int i = 0; i < 4; i++) bit_cycle(1'b1, d, o);
        cs_high();
        check("R10 partial byte dropped", cfg_regs, model_flat());
        run_frame("R11 fresh frame after abort", 1'b1, 2'b00, 13'd4, 1, -1);

        // R11 streaming code with no data ends at the boundary
        run_frame("R11 empty stream", 1'b0, 2'b11, 13'd2, 0, -1);
        run_frame("R11 frame after empty", 1'b1, 2'b00, 13'd3, 1, -1);

        // R6 switch to LSB-first, then increments (R5)
        wbuf[0] = 8'h01;
        run_frame("R6 set order", 1'b0, 2'b00, 13'd0, 1, -1);
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3D;
        run_frame("R6 lsb write", 1'b0, 2'b01, 13'd5, 2, -1);
        check("R5 increment lands at 6", cfg_regs[6*8 +: 8], 8'h3D);
        check("R6 lsb byte order at 5", cfg_regs[5*8 +: 8], 8'hC3);
        run_frame("R6 lsb read", 1'b1, 2'b01, 13'd5, 2, -1);

        for (int n = 0; n < 40; n++) begin
            bit rd;
            bit [1:0] wc;
            bit [12:0] a;
            int cnt, nb, st;
            rd  = 1'($urandom % 2);
            wc  = 2'($urandom % 4);
            cnt = (wc == 2'b11) ? 0 : int'(wc) + 1;
            nb  = (wc == 2'b11) ? 1 + int'($urandom % 4) : cnt + int'($urandom % 2);
            a   = ($urandom % 5 == 0) ? 13'd8190 + 13'($urandom % 2) : 13'($urandom % 20);
            st  = (cnt > 1 && $urandom % 2 == 1) ? 1 + int'($urandom % (cnt - 1)) : -1;
            for (int k = 0; k < nb; k++) wbuf[k] = 8'($urandom);
            run_frame(rd ? "R3 R4 R7 random read" : "R2 R4 R7 random write", rd, wc, a, nb, st);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule